// File: doc/BRIEF.md
# Strap-Configured Shared Address/GPIO Pin Controller

This block owns four chip pins that can carry either the top four address bits of the bus or general-purpose I/O. A two-bit strap value, captured only while reset is held, sets the power-up personality:

- all outputs floating;
- the four pins held as undriven inputs, with two request inputs masked;
- the pins acting as plain address outputs;
- a reserved test code, which this block handles as floating.

After reset, software writes three registers to hand each pin over to I/O: an output-value register, a direction register and a select register. The recommended order is output values first, then directions, then selects. This order means a pin never briefly drives a stale level when it changes function.

Each pin is controlled by its own select bit and direction bit. When the select bit is clear, the pin carries its address bit and its output enable is on. When the select bit is set, the direction bit decides between two cases: driving the stored output value, or floating as an input. Two upper select bits gate the bus-request and DMA-request inputs on their way into the core. While a gate is closed, the core sees the inactive level.

A fourth register address returns the pin levels after a two-stage synchronizer. The register port is a plain single-cycle write strobe with a combinational read mux. The block has no streaming data path, so no valid/ready handshake is needed.

Top module: `strap_pin_ctrl`

## Requirements
- R1: Strap code 2'b00 makes `float_all` 1 and holds every bit of `pin_oe` at 0, whatever the registers hold.
- R2: Strap code 2'b11 (reserved) behaves exactly as code 2'b00: `float_all` 1 and `pin_oe` all 0.
- R3: Strap code 2'b01 resets the select register to 16'hC00F and the output-value and direction registers to 0. As a result no pin drives (`pin_oe` = 0) until software writes the registers.
- R4: Strap code 2'b10 resets all three registers to 0. Every pin then drives its `addr_bit_i` value with `pin_oe` = 1, and `float_all` is 0.
- R5: Outside the floating codes, pin i behaves as follows:
  - with select bit i equal to 0, it outputs `addr_bit_i[i]` with enable 1;
  - with select bit i equal to 1 and direction bit i equal to 1, it outputs output-value bit i with enable 1;
  - with select bit i equal to 1 and direction bit i equal to 0, its enable is 0.
- R6: While select bit 14 is 1, `bus_req_n_o` is 1; otherwise it equals `bus_req_n_i`. Select bit 15 gates `dma_req_n_i` onto `dma_req_n_o` in the same way.
- R7: `strap_code` is sampled only on clock edges while `rst_n` is 0. Changes after reset release alter neither `float_all`, `pin_oe` nor the select register.
- R8: The register addresses are:
  - 0: output value, bits [3:0];
  - 1: direction, bits [3:0];
  - 2: select, all 16 bits.
  A write takes effect on the clock edge where `wr_en` is 1. Reads return unused upper bits as 0. Writes to address 3 change nothing.
- R9: Reading address 3 returns `pin_in` delayed by exactly two rising clock edges. The value is in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are sampled while low |
| strap_code | input | 2 | Power-up personality strap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| addr_bit_i | input | 4 | Address bits from the bus unit |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output levels |
| pin_oe | output | 4 | Pad output enables |
| float_all | output | 1 | Request to float all chip outputs |
| bus_req_n_i | input | 1 | Raw bus-request input, active low |
| bus_req_n_o | output | 1 | Gated bus request to the core |
| dma_req_n_i | input | 1 | Raw DMA-request input, active low |
| dma_req_n_o | output | 1 | Gated DMA request to the core |

## Verification
The bench resets the block under all four strap codes. It checks the following:

- **Reset values.** A design that loaded one fixed select value would leave the pins driving in input-pin mode, or masking requests in normal mode.
- **Reserved code.** A design that let code 11 run as a normal mode would drive the pins.
- **Strap changes after reset.** These go through every strap code. A design that kept sampling would flip personality at run time.
- **Synchronizer latency.** The readback is probed one edge and two edges after a pin change. Dropping or adding a stage shows up as a one-cycle error.
- **Random sequences.** Random register traffic, address bits and request inputs are compared against a per-pin model in normal, input-pin and floating modes.

// File: rtl/strap_pin_pkg.sv
package strap_pin_pkg;

  typedef enum logic [1:0] {
    MODE_FLOAT  = 2'b00,
    MODE_INPIN  = 2'b01,
    MODE_NORMAL = 2'b10,
    MODE_TEST   = 2'b11
  } strap_mode_e;

  typedef enum logic [1:0] {
    REG_OUT = 2'd0,
    REG_DIR = 2'd1,
    REG_SEL = 2'd2,
    REG_IN  = 2'd3
  } reg_addr_e;

  // Select-register value loaded during reset for a given strap code.
  function automatic logic [15:0] sel_reset_value(
    input logic [1:0] code,
    input int         npins,
    input int         breq_bit,
    input int         dreq_bit
  );
    logic [15:0] v;
    v = '0;
    if (code == MODE_INPIN) begin
      for (int i = 0; i < npins; i++) v[i] = 1'b1;
      v[breq_bit] = 1'b1;
      v[dreq_bit] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_i,
  output strap_mode_e mode_o,
  output logic        float_o
);

  strap_mode_e mode_q;

  // Straps load on every edge while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= strap_mode_e'(strap_i);
  end

  // Reserved code is mapped onto the safe floating personality.
  always_comb begin
    unique case (mode_q)
      MODE_FLOAT, MODE_TEST: float_o = 1'b1;
      default:               float_o = 1'b0;
    endcase
  end

  assign mode_o = mode_q;

  // R7
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

endmodule

// File: rtl/pin_regs.sv
module pin_regs
  import strap_pin_pkg::*;
#(
  parameter int NPINS    = 4,
  parameter int SEL_W    = 16,
  parameter int BREQ_BIT = 14,
  parameter int DREQ_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [SEL_W-1:0] wr_data_i,
  output logic [NPINS-1:0] out_o,
  output logic [NPINS-1:0] dir_o,
  output logic [SEL_W-1:0] sel_o
);

  logic [NPINS-1:0] out_q, dir_q;
  logic [SEL_W-1:0] sel_q;
  logic [15:0]      sel_rst;

  assign sel_rst = sel_reset_value(strap_i, NPINS, BREQ_BIT, DREQ_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      sel_q <= sel_rst[SEL_W-1:0];
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        REG_OUT: out_q <= wr_data_i[NPINS-1:0];
        REG_DIR: dir_q <= wr_data_i[NPINS-1:0];
        REG_SEL: sel_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
  assign sel_o = sel_q;

  // R8
  write_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == REG_SEL) |=> sel_q == $past(wr_data_i));

endmodule

// File: rtl/pin_mux.sv
module pin_mux #(
  parameter int NPINS = 4
) (
  input  logic             float_i,
  input  logic [NPINS-1:0] sel_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] out_i,
  input  logic [NPINS-1:0] addr_i,
  output logic [NPINS-1:0] pin_out_o,
  output logic [NPINS-1:0] pin_oe_o
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      if (sel_i[i]) begin
        pin_out_o[i] = out_i[i];
        pin_oe_o[i]  = dir_i[i] & ~float_i;
      end else begin
        pin_out_o[i] = addr_i[i];
        pin_oe_o[i]  = ~float_i;
      end
    end
  end

endmodule

// File: rtl/in_sync.sv
module in_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    s1_q <= d_i;
    s2_q <= s1_q;
  end

  assign q_o = s2_q;

  // R9
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o == $past(d_i, 2));

endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
  import strap_pin_pkg::*;
#(
  parameter int NPINS    = 4,
  parameter int SEL_W    = 16,
  parameter int BREQ_BIT = 14,
  parameter int DREQ_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_code,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [SEL_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [SEL_W-1:0] rd_data,
  input  logic [NPINS-1:0] addr_bit_i,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             float_all,
  input  logic             bus_req_n_i,
  output logic             bus_req_n_o,
  input  logic             dma_req_n_i,
  output logic             dma_req_n_o
);

  localparam int PAD_W = SEL_W - NPINS;

  strap_mode_e      mode;
  logic             float_w;
  logic [NPINS-1:0] out_r, dir_r, sync_in;
  logic [SEL_W-1:0] sel_r;

  strap_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_code),
    .mode_o  (mode),
    .float_o (float_w)
  );

  pin_regs #(
    .NPINS(NPINS), .SEL_W(SEL_W), .BREQ_BIT(BREQ_BIT), .DREQ_BIT(DREQ_BIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (strap_code),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .out_o     (out_r),
    .dir_o     (dir_r),
    .sel_o     (sel_r)
  );

  pin_mux #(.NPINS(NPINS)) u_mux (
    .float_i   (float_w),
    .sel_i     (sel_r[NPINS-1:0]),
    .dir_i     (dir_r),
    .out_i     (out_r),
    .addr_i    (addr_bit_i),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe)
  );

  in_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in),
    .q_o   (sync_in)
  );

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      REG_OUT: rd_data = {{PAD_W{1'b0}}, out_r};
      REG_DIR: rd_data = {{PAD_W{1'b0}}, dir_r};
      REG_SEL: rd_data = sel_r;
      default: rd_data = {{PAD_W{1'b0}}, sync_in};
    endcase
  end

  assign bus_req_n_o = bus_req_n_i | sel_r[BREQ_BIT];
  assign dma_req_n_o = dma_req_n_i | sel_r[DREQ_BIT];
  assign float_all   = float_w;

  // R1
  float_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    float_all |-> pin_oe == '0);

  // R3
  inpin_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INPIN && $past(!rst_n)) |-> pin_oe == '0);

  // R5
  input_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_r[NPINS-1:0] & ~dir_r & pin_oe) == '0));

endmodule

// File: tb/strap_pin_ctrl_bench.sv
module strap_pin_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  strap_code = 2'b10;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [1:0]  rd_addr = 0;
  logic [15:0] rd_data;
  logic [3:0]  addr_bit_i = 0, pin_in = 0, pin_out, pin_oe;
  logic        float_all;
  logic        bus_req_n_i = 1, bus_req_n_o, dma_req_n_i = 1, dma_req_n_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [3:0]  m_out, m_dir;
  logic [15:0] m_sel;
  logic        m_float;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_pin_ctrl u_strap_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_code(strap_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .addr_bit_i(addr_bit_i), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .float_all(float_all),
    .bus_req_n_i(bus_req_n_i), .bus_req_n_o(bus_req_n_o),
    .dma_req_n_i(dma_req_n_i), .dma_req_n_o(dma_req_n_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_oe();
    logic [3:0] v;
    for (int i = 0; i < 4; i++)
      v[i] = m_float ? 1'b0 : (m_sel[i] ? m_dir[i] : 1'b1);
    return v;
  endfunction

  function automatic logic [3:0] exp_out();
    logic [3:0] v;
    for (int i = 0; i < 4; i++)
      v[i] = m_sel[i] ? m_out[i] : addr_bit_i[i];
    return v;
  endfunction

  task automatic do_reset(logic [1:0] code);
    @(negedge clk);
    rst_n = 0;
    strap_code = code;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_out = 0;
    m_dir = 0;
    m_sel = (code == 2'b01) ? 16'hC00F : 16'h0000;
    m_float = (code == 2'b00) || (code == 2'b11);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      2'd0: m_out = d[3:0];
      2'd1: m_dir = d[3:0];
      2'd2: m_sel = d;
      default: ;
    endcase
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [15:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic pins_check(string req);
    #1;
    check(req, pin_oe, exp_oe());
    for (int i = 0; i < 4; i++)
      if (exp_oe()[i]) check(req, pin_out[i], exp_out()[i]);
    check(req, float_all, m_float);
    check(req, bus_req_n_o, bus_req_n_i | m_sel[14]);
    check(req, dma_req_n_o, dma_req_n_i | m_sel[15]);
  endtask

  task automatic random_phase(string req, int n);
    for (int k = 0; k < n; k++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      addr_bit_i  = 4'($urandom);
      bus_req_n_i = 1'($urandom);
      dma_req_n_i = 1'($urandom);
      wr(a, 16'($urandom));
      pins_check(req);
      rd_check("R8", 2'd2, m_sel);
      rd_check("R8", 2'd0, {12'b0, m_out});
      rd_check("R8", 2'd1, {12'b0, m_dir});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));

    // R4 normal strap
    do_reset(2'b10);
    addr_bit_i = 4'hA;
    pins_check("R4");
    rd_check("R4", 2'd2, 16'h0000);
    check("R4", pin_oe, 4'hF);

    // R5 per-pin mux, directed
    wr(2'd0, 16'h0005);
    wr(2'd1, 16'h0003);
    wr(2'd2, 16'h000F);
    pins_check("R5");
    check("R5", pin_oe, 4'h3);
    // R8 write to read-only address ignored
    wr(2'd3, 16'hFFFF);
    rd_check("R8", 2'd0, 16'h0005);
    rd_check("R8", 2'd1, 16'h0003);
    rd_check("R8", 2'd2, 16'h000F);
    pins_check("R8");
    random_phase("R5", 150);

    // R6 request gating, directed
    wr(2'd2, 16'h4000);
    bus_req_n_i = 0;
    dma_req_n_i = 0;
    #1;
    check("R6", bus_req_n_o, 1'b1);
    check("R6", dma_req_n_o, 1'b0);
    wr(2'd2, 16'h8000);
    #1;
    check("R6", bus_req_n_o, 1'b0);
    check("R6", dma_req_n_o, 1'b1);

    // R9 synchronizer latency
    pin_in = 4'h0;
    repeat (3) @(negedge clk);
    pin_in = 4'h9;
    @(negedge clk);
    rd_check("R9", 2'd3, 16'h0000);
    @(negedge clk);
    rd_check("R9", 2'd3, 16'h0009);

    // R3 input-pin strap
    do_reset(2'b01);
    rd_check("R3", 2'd2, 16'hC00F);
    rd_check("R3", 2'd0, 16'h0000);
    rd_check("R3", 2'd1, 16'h0000);
    bus_req_n_i = 0;
    dma_req_n_i = 0;
    pins_check("R3");
    check("R3", pin_oe, 4'h0);

    // R7 strap changes after reset ignored
    for (int c = 0; c < 4; c++) begin
      strap_code = 2'(c);
      repeat (2) @(negedge clk);
      pins_check("R7");
      rd_check("R7", 2'd2, 16'hC00F);
    end
    random_phase("R3", 60);

    // R1 floating strap
    do_reset(2'b00);
    check("R1", float_all, 1'b1);
    check("R1", pin_oe, 4'h0);
    random_phase("R1", 40);

    // R2 reserved strap
    do_reset(2'b11);
    check("R2", float_all, 1'b1);
    check("R2", pin_oe, 4'h0);
    random_phase("R2", 40);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule